// File: doc/BRIEF.md
# Shared AHB-Lite Bus Interconnect with Error Responder

This block joins several AHB-Lite masters (for example an on-chip processor and a bridge driven by an external test host) to a set of AHB-Lite slaves over one shared bus layer. One master at a time owns the address phase. Its address and control signals go to every slave. The slave select lines come from a region table held in two parameters, one giving the base address of each region and one giving the log2 of its size. To add or remove a slave, edit that table and the slave count. Nothing else changes.

An address that falls in no region selects a built-in error responder. An active transfer to such an address finishes with an ERROR response and never stalls, so a stray pointer cannot hang the bus. The slave select and the owning master are captured at the end of each address phase. This lets read data, response and ready return to the master whose data phase is in flight, while the next master's address is already on the bus. Write data is taken from that same master.

Master ports are flat vectors with one slice per master. Master index 0 has the highest priority and is meant for the external host. The read-data output is shared by all masters.

Top module: `ahb_shared_bus`

## Requirements
- R1: After reset, master 0 owns the address phase, and all masters driving IDLE (HTRANS 2'b00) see ready high and response OKAY (0). The slave-side ready is high.
- R2: Slave select bit i is high exactly when the address bits above the region's size field equal those bits of its base. At most one select is high. A completed read returns the selected slave's data with OKAY.
- R3: An accepted NONSEQ (2'b10) or SEQ (2'b11) transfer to an address outside every region gets a two-cycle reply. In the first data cycle ready is low and response is ERROR (1). In the second data cycle ready is high and response is ERROR.
- R4: An accepted IDLE (2'b00) or BUSY (2'b01) transfer to an unmapped address completes in its first data cycle with OKAY.
- R5: The address-phase owner changes only on a clock edge where bus ready is high and the owner drives IDLE. An owner issuing back-to-back active transfers keeps the bus.
- R6: At a handover, the requesting master with the lowest index wins. A request means HTRANS bit 1 is set. If no other master requests, the owner is kept.
- R7: A master that does not own the address phase sees ready low while it requests, and ready high while it is idle.
- R8: Write data to the slaves comes from the data-phase master. Read data and response come from the data-phase slave. Only the data-phase master can see ERROR; all other masters see OKAY.
- R9: While the data-phase slave holds its ready low, the owner's ready and the slave-side ready are low. The next address stays on the bus until the slave completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_htrans | input | NM*2 | Transfer type per master |
| m_haddr | input | NM*AW | Address per master |
| m_hwrite | input | NM | Write flag per master |
| m_hsize | input | NM*3 | Transfer size per master |
| m_hburst | input | NM*3 | Burst type per master |
| m_hwdata | input | NM*DW | Write data per master |
| m_hready | output | NM | Ready per master |
| m_hresp | output | NM | Response per master |
| m_hrdata | output | DW | Shared read data |
| s_hsel | output | NS | One select per slave |
| s_haddr | output | AW | Shared slave address |
| s_htrans | output | 2 | Shared transfer type |
| s_hwrite | output | 1 | Shared write flag |
| s_hsize | output | 3 | Shared transfer size |
| s_hburst | output | 3 | Shared burst type |
| s_hwdata | output | DW | Shared write data |
| s_hready | output | 1 | Bus ready returned to all slaves |
| s_hreadyout | input | NS | Ready from each slave |
| s_hresp | input | NS | Response from each slave |
| s_hrdata | input | NS*DW | Read data from each slave |

## Verification
The bench builds the block with three masters, three slaves, a 12-bit address and 8-bit data. Its regions are 256, 512 and 128 bytes at 0x000, 0x400 and 0x800. The small address space allows a full sweep of all 4096 addresses, covering both mapped regions and unmapped gaps, and every result is compared with a decode computed in the bench. The middle slave inserts a wait state, which exercises the stall path. With a third master, two requesters can compete at a handover while a third master owns the bus, so the index priority is tested as well as the plain handover.

// File: rtl/ahb_ic_pkg.sv
// Shared encodings for the shared AHB-Lite bus interconnect.
// Assumes standard AHB-Lite transfer type and response codes.
package ahb_ic_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RSP_OKAY  = 1'b0;
    localparam logic RSP_ERROR = 1'b1;

    typedef enum logic [1:0] {
        ER_QUIET = 2'b00,
        ER_FIRST = 2'b01,
        ER_LAST  = 2'b10
    } err_state_e;

endpackage

// File: rtl/ahb_owner_arb.sv
// Address-phase owner selection. The owner is kept while it drives active
// or BUSY transfers, or while the bus is stalled. On a ready edge with an
// idle owner, the lowest-index requester takes over. Also records which
// master owns the data phase.
// Assumes: req[i] is bit 1 of master i's HTRANS.
module ahb_owner_arb #(
    parameter int NM = 2,
    parameter int OW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          owner_idle,
    input  logic          bus_ready,
    output logic [OW-1:0] a_own,
    output logic [OW-1:0] d_own
);

    logic [OW-1:0] a_own_q, d_own_q, a_own_nxt;
    logic          found;

    // Pick the next owner at a transfer boundary where the current owner is idle.
    always_comb begin
        a_own_nxt = a_own_q;
        found     = 1'b0;
        if (bus_ready && owner_idle) begin
            for (int i = 0; i < NM; i++) begin
                if (req[i] && !found) begin
                    a_own_nxt = OW'(i);
                    found     = 1'b1;
                end
            end
        end
    end

    // Hold the owner registers; the data-phase owner follows each accepted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_own_q <= '0;
            d_own_q <= '0;
        end else begin
            a_own_q <= a_own_nxt;
            if (bus_ready) d_own_q <= a_own_q;
        end
    end

    assign a_own = a_own_q;
    assign d_own = d_own_q;

endmodule

// File: rtl/ahb_map_decode.sv
// Region decoder built from the base and log2-size table. Elaboration stops
// on a base not aligned to its size, or on two overlapping regions.
// Assumes MAP_BITS values are below or equal to AW.
module ahb_map_decode #(
    parameter int                  NS       = 3,
    parameter int                  AW       = 32,
    parameter logic [NS*AW-1:0]    MAP_BASE = '0,
    parameter logic [NS*8-1:0]     MAP_BITS = '0
) (
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] hit,
    output logic          miss
);

    for (genvar g = 0; g < NS; g++) begin : g_region
        localparam logic [AW-1:0] BASE = MAP_BASE[g*AW +: AW];
        localparam int            BITS = int'(MAP_BITS[g*8 +: 8]);
        localparam logic [AW-1:0] LOW  = BASE & ((AW'(1) << BITS) - AW'(1));

        if (LOW != '0) begin : g_bad_align
            $error("region %0d base not aligned to its size", g);
        end

        for (genvar h = g + 1; h < NS; h++) begin : g_pair
            localparam logic [AW-1:0] OBASE = MAP_BASE[h*AW +: AW];
            localparam int            OBITS = int'(MAP_BITS[h*8 +: 8]);
            localparam int            WIDE  = (BITS > OBITS) ? BITS : OBITS;
            if ((BASE >> WIDE) == (OBASE >> WIDE)) begin : g_overlap
                $error("regions %0d and %0d overlap", g, h);
            end
        end

        // Compare the address bits above the region size field.
        always_comb hit[g] = ((addr >> BITS) == (BASE >> BITS));
    end

    assign miss = ~|hit;

endmodule

// File: rtl/ahb_err_responder.sv
// Built-in slave for unmapped addresses: two-cycle ERROR for active
// transfers, zero-wait OKAY otherwise.
// Assumes take is high only on a ready edge carrying an active unmapped transfer.
module ahb_err_responder
    import ahb_ic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic hreadyout,
    output logic hresp
);

    err_state_e st_q, st_nxt;

    // Sequence through the two response cycles.
    always_comb begin
        st_nxt = st_q;
        case (st_q)
            ER_FIRST: st_nxt = ER_LAST;
            default:  st_nxt = take ? ER_FIRST : ER_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ER_QUIET;
        else        st_q <= st_nxt;
    end

    assign hreadyout = (st_q != ER_FIRST);
    assign hresp     = (st_q == ER_QUIET) ? RSP_OKAY : RSP_ERROR;

endmodule

// File: rtl/ahb_shared_bus.sv
// Single shared AHB-Lite layer: NM masters, NS table-decoded slaves, and an
// error responder for unmapped space. Captures the slave select and the
// owner at each accepted address phase to steer the data phase.
// Assumes masters follow AHB-Lite: they hold address and control while their ready is low.
module ahb_shared_bus
    import ahb_ic_pkg::*;
#(
    parameter int               NM       = 2,
    parameter int               NS       = 3,
    parameter int               AW       = 32,
    parameter int               DW       = 32,
    parameter logic [NS*AW-1:0] MAP_BASE = {32'h4000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [NS*8-1:0]  MAP_BITS = {8'd12, 8'd16, 8'd16}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM*2-1:0]  m_htrans,
    input  logic [NM*AW-1:0] m_haddr,
    input  logic [NM-1:0]    m_hwrite,
    input  logic [NM*3-1:0]  m_hsize,
    input  logic [NM*3-1:0]  m_hburst,
    input  logic [NM*DW-1:0] m_hwdata,
    output logic [NM-1:0]    m_hready,
    output logic [NM-1:0]    m_hresp,
    output logic [DW-1:0]    m_hrdata,
    output logic [NS-1:0]    s_hsel,
    output logic [AW-1:0]    s_haddr,
    output logic [1:0]       s_htrans,
    output logic             s_hwrite,
    output logic [2:0]       s_hsize,
    output logic [2:0]       s_hburst,
    output logic [DW-1:0]    s_hwdata,
    output logic             s_hready,
    input  logic [NS-1:0]    s_hreadyout,
    input  logic [NS-1:0]    s_hresp,
    input  logic [NS*DW-1:0] s_hrdata
);

    localparam int OW = (NM > 1) ? $clog2(NM) : 1;

    logic [OW-1:0] a_own, d_own;
    logic [NM-1:0] req;
    logic [NS-1:0] hit;
    logic          miss;
    logic [NS:0]   dsel_q;
    logic          bus_ready, bus_resp;
    logic          dflt_ready, dflt_resp;
    logic [DW-1:0] bus_rdata;

    for (genvar gm = 0; gm < NM; gm++) begin : g_master
        assign req[gm]      = m_htrans[2*gm+1];
        assign m_hready[gm] = (a_own == OW'(gm)) ? bus_ready : !req[gm];
        assign m_hresp[gm]  = (d_own == OW'(gm)) && bus_resp;
    end

    ahb_owner_arb #(.NM(NM), .OW(OW)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .owner_idle (s_htrans == TR_IDLE),
        .bus_ready  (bus_ready),
        .a_own      (a_own),
        .d_own      (d_own)
    );

    // Address-phase mux from the owning master.
    always_comb begin
        s_haddr  = m_haddr[int'(a_own)*AW +: AW];
        s_htrans = m_htrans[int'(a_own)*2 +: 2];
        s_hwrite = m_hwrite[a_own];
        s_hsize  = m_hsize[int'(a_own)*3 +: 3];
        s_hburst = m_hburst[int'(a_own)*3 +: 3];
        s_hwdata = m_hwdata[int'(d_own)*DW +: DW];
    end

    ahb_map_decode #(.NS(NS), .AW(AW), .MAP_BASE(MAP_BASE), .MAP_BITS(MAP_BITS)) i_dec (
        .addr (s_haddr),
        .hit  (hit),
        .miss (miss)
    );

    assign s_hsel = hit;

    ahb_err_responder i_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (bus_ready && miss && s_htrans[1]),
        .hreadyout (dflt_ready),
        .hresp     (dflt_resp)
    );

    // Capture the data-phase slave select at each accepted address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         dsel_q <= {1'b1, {NS{1'b0}}};
        else if (bus_ready) dsel_q <= {miss, hit};
    end

    // Return path mux from the data-phase slave.
    always_comb begin
        bus_ready = |(dsel_q & {dflt_ready, s_hreadyout});
        bus_resp  = |(dsel_q & {dflt_resp, s_hresp});
        bus_rdata = '0;
        for (int i = 0; i < NS; i++) begin
            if (dsel_q[i]) bus_rdata = bus_rdata | s_hrdata[i*DW +: DW];
        end
    end

    assign s_hready = bus_ready;
    assign m_hrdata = bus_rdata;

endmodule

// File: rtl/ahb_shared_bus_chk.sv
// Protocol checker for ahb_shared_bus, attached by bind below.
// Assumes it sees the owner index and request vector of the top module.
module ahb_shared_bus_chk #(
    parameter int NM = 2,
    parameter int NS = 3,
    parameter int OW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] s_hsel,
    input logic          s_hready,
    input logic [1:0]    s_htrans,
    input logic [NM-1:0] m_hready,
    input logic [NM-1:0] m_hresp,
    input logic [NM-1:0] req,
    input logic [OW-1:0] a_own
);

    AST_HSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_hsel)); // R2
    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hready && s_htrans[1] && s_hsel == '0) |=> (!s_hready && (|m_hresp))); // R3
    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_hready && (|m_hresp)) |=> (s_hready && (|m_hresp))); // R3
    AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hready && !s_htrans[1] && s_hsel == '0) |=> (s_hready && m_hresp == '0)); // R4
    AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_hready || s_htrans != 2'b00) |=> $stable(a_own)); // R5
    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_hready & req) <= 1); // R7
    AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_hresp)); // R8

endmodule

bind ahb_shared_bus ahb_shared_bus_chk #(.NM(NM), .NS(NS), .OW(OW)) i_chk (.*);

// File: tb/test_ahb_shared_bus.sv
module test_ahb_shared_bus;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int NS = 3;
    localparam int AW = 12;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]    mt  [NM];
    logic [AW-1:0] ma  [NM];
    logic          mw  [NM];
    logic [DW-1:0] mwd [NM];

    logic [NM*2-1:0]  m_htrans;
    logic [NM*AW-1:0] m_haddr;
    logic [NM-1:0]    m_hwrite;
    logic [NM*3-1:0]  m_hsize, m_hburst;
    logic [NM*DW-1:0] m_hwdata;
    logic [NM-1:0]    m_hready, m_hresp;
    logic [DW-1:0]    m_hrdata;
    logic [NS-1:0]    s_hsel;
    logic [AW-1:0]    s_haddr;
    logic [1:0]       s_htrans;
    logic             s_hwrite;
    logic [2:0]       s_hsize, s_hburst;
    logic [DW-1:0]    s_hwdata;
    logic             s_hready;
    logic [NS-1:0]    s_hreadyout, s_hresp;
    logic [NS*DW-1:0] s_hrdata;

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_htrans[m*2 +: 2]   = mt[m];
            m_haddr[m*AW +: AW]  = ma[m];
            m_hwrite[m]          = mw[m];
            m_hsize[m*3 +: 3]    = 3'd0;
            m_hburst[m*3 +: 3]   = 3'd0;
            m_hwdata[m*DW +: DW] = mwd[m];
        end
    end

    ahb_shared_bus #(
        .NM(NM), .NS(NS), .AW(AW), .DW(DW),
        .MAP_BASE({12'h800, 12'h400, 12'h000}),
        .MAP_BITS({8'd7, 8'd9, 8'd8})
    ) i_ahb_shared_bus (.*);

    // Expected region index for an address, -1 when unmapped.
    function automatic int exp_slave(input int a);
        if ((a >> 8) == 0)           return 0;
        if ((a >> 9) == (12'h400 >> 9)) return 1;
        if ((a >> 7) == (12'h800 >> 7)) return 2;
        return -1;
    endfunction

    function automatic int ws_of(input int s);
        return (s == 1) ? 1 : 0;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input int a, input int s);
        return 8'(a) ^ (8'(s + 1) * 8'h11);
    endfunction

    // Behavioural slaves: slave 1 adds one wait state to active transfers.
    logic [AW-1:0] dp_addr [NS];
    logic          dp_act  [NS];
    logic          dp_wr   [NS];
    int            wcnt    [NS];
    logic [DW-1:0] wr_seen [NS];

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) begin
                dp_addr[s] <= '0; dp_act[s] <= 1'b0; dp_wr[s] <= 1'b0;
                wcnt[s] <= 0; wr_seen[s] <= '0;
            end else begin
                if (dp_act[s] && dp_wr[s] && wcnt[s] == 0 && s_hready) wr_seen[s] <= s_hwdata;
                if (s_hready) begin
                    dp_act[s]  <= s_hsel[s] && s_htrans[1];
                    dp_wr[s]   <= s_hwrite;
                    dp_addr[s] <= s_haddr;
                    wcnt[s]    <= (s_hsel[s] && s_htrans[1]) ? ws_of(s) : 0;
                end else if (wcnt[s] > 0) begin
                    wcnt[s] <= wcnt[s] - 1;
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            s_hreadyout[s]         = (wcnt[s] == 0);
            s_hresp[s]             = 1'b0;
            s_hrdata[s*DW +: DW]   = exp_rd(int'(dp_addr[s]), s);
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < NM; m++) begin
            mt[m] = 2'b00; ma[m] = '0; mw[m] = 1'b0; mwd[m] = '0;
        end
        ma[0] = 12'h055; ma[1] = 12'h0AA;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        smp();
        // R1: reset state
        chk(m_hready == 3'b111, "R1", m_hready, 3'b111);
        chk(m_hresp == 3'b000, "R1", m_hresp, 0);
        chk(s_hready == 1'b1, "R1", s_hready, 1);
        chk(s_haddr == 12'h055, "R1", s_haddr, 12'h055);

        // R2 R3 R9: sweep every address from master 0
        for (int a = 0; a < 4096; a++) begin
            int es, waits;
            logic [NS-1:0] esel;
            step();
            mt[0] = 2'b10; ma[0] = AW'(a); mw[0] = 1'b0;
            smp();
            es = exp_slave(a);
            esel = (es < 0) ? '0 : NS'(1 << es);
            chk(s_hsel == esel, "R2", s_hsel, esel);
            step();
            mt[0] = 2'b00;
            smp();
            if (es < 0) begin
                chk(!m_hready[0] && m_hresp[0], "R3", {m_hready[0], m_hresp[0]}, 2'b01);
                step(); smp();
                chk(m_hready[0] && m_hresp[0], "R3", {m_hready[0], m_hresp[0]}, 2'b11);
            end else begin
                waits = 0;
                while (!m_hready[0] && waits < 8) begin
                    step(); smp(); waits++;
                end
                chk(waits == ws_of(es), "R9", waits, ws_of(es));
                chk(!m_hresp[0] && m_hrdata == exp_rd(a, es), "R2", m_hrdata, exp_rd(a, es));
            end
        end

        // R4: IDLE and BUSY to unmapped space
        step(); mt[0] = 2'b00; ma[0] = 12'hF00;
        smp(); step(); smp();
        chk(m_hready[0] && !m_hresp[0], "R4", {m_hready[0], m_hresp[0]}, 2'b10);
        step(); mt[0] = 2'b01; ma[0] = 12'hF04;
        smp(); step(); mt[0] = 2'b00;
        smp();
        chk(m_hready[0] && !m_hresp[0], "R4", {m_hready[0], m_hresp[0]}, 2'b10);

        // R5 R7: handover from idle master 0 to master 1
        step(); ma[0] = 12'h123; mt[1] = 2'b10; ma[1] = 12'h010;
        smp();
        chk(!m_hready[1], "R7", m_hready[1], 0);
        chk(m_hready[2], "R7", m_hready[2], 1);
        chk(s_haddr == 12'h123, "R5", s_haddr, 12'h123);
        step(); smp();
        chk(s_haddr == 12'h010 && m_hready[1], "R5", s_haddr, 12'h010);
        step(); ma[1] = 12'h020; mt[0] = 2'b10; ma[0] = 12'h030;
        smp();
        chk(s_haddr == 12'h020, "R5", s_haddr, 12'h020);
        chk(!m_hready[0], "R7", m_hready[0], 0);
        chk(m_hrdata == exp_rd(12'h010, 0) && m_hresp == 0, "R8", m_hrdata, exp_rd(12'h010, 0));
        step(); mt[1] = 2'b00;
        smp();
        chk(m_hrdata == exp_rd(12'h020, 0), "R8", m_hrdata, exp_rd(12'h020, 0));
        chk(!m_hready[0], "R5", m_hready[0], 0);
        step(); smp();
        chk(s_haddr == 12'h030 && m_hready[0], "R5", s_haddr, 12'h030);

        // R6: masters 1 and 2 compete while master 0 goes idle
        step(); mt[0] = 2'b00; mt[1] = 2'b10; ma[1] = 12'h041; mt[2] = 2'b10; ma[2] = 12'h042;
        smp();
        chk(m_hrdata == exp_rd(12'h030, 0), "R8", m_hrdata, exp_rd(12'h030, 0));
        step(); smp();
        chk(s_haddr == 12'h041 && m_hready[1] && !m_hready[2], "R6", s_haddr, 12'h041);
        step(); mt[1] = 2'b00; mt[0] = 2'b10; ma[0] = 12'h050;
        smp();
        step(); smp();
        chk(s_haddr == 12'h050 && m_hready[0] && !m_hready[2], "R6", s_haddr, 12'h050);

        // R8: write data and error steering
        step(); mt[0] = 2'b10; ma[0] = 12'h060; mw[0] = 1'b1;
        smp();
        step(); mt[0] = 2'b10; ma[0] = 12'hF00; mw[0] = 1'b0;
        mwd[0] = 8'hA5; mwd[1] = 8'h3C; mwd[2] = 8'h5A;
        smp();
        chk(s_hwdata == 8'hA5, "R8", s_hwdata, 8'hA5);
        step(); mt[0] = 2'b00;
        smp();
        chk(m_hresp == 3'b001, "R8", m_hresp, 3'b001);
        chk(!m_hready[0] && m_hresp[0], "R3", {m_hready[0], m_hresp[0]}, 2'b01);
        chk(!m_hready[2], "R7", m_hready[2], 0);
        chk(wr_seen[0] == 8'hA5, "R8", wr_seen[0], 8'hA5);
        step(); smp();
        chk(m_hready[0] && m_hresp == 3'b001, "R3", m_hresp, 3'b001);
        step(); smp();
        chk(s_haddr == 12'h042 && m_hready[2], "R6", s_haddr, 12'h042);

        // R9: wait state from slave 1 stalls the owner
        step(); ma[2] = 12'h400;
        step(); ma[2] = 12'h044;
        smp();
        chk(!m_hready[2] && !s_hready, "R9", {m_hready[2], s_hready}, 0);
        chk(s_haddr == 12'h044, "R9", s_haddr, 12'h044);
        step(); smp();
        chk(m_hready[2] && m_hrdata == exp_rd(12'h400, 1), "R9", m_hrdata, exp_rd(12'h400, 1));
        step(); mt[2] = 2'b00;
        smp();
        chk(m_hready[2] && m_hrdata == exp_rd(12'h044, 0), "R9", m_hrdata, exp_rd(12'h044, 0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule